// File: doc/BRIEF.md
# Three-Wire Panel Register Slave

This block is the device end of a three-wire configuration link (enable, clock, data) used to set up a display panel. The master raises the enable line, then clocks out a frame: a 6-bit register address, a direction bit, one idle turnaround clock and 8 data bits. On a write the slave shifts in the 8 data bits and commits them to its register file once the last bit has arrived. On a read it takes over the data line after the turnaround clock and returns the addressed register, most significant bit first.

The link signals are asynchronous to the block. The block samples them with its own system clock through a synchronizer and detects the link clock edges. Four registers are mapped. The first is a free scratch byte. The second is a fixed identification byte: a chip identifier in the upper nibble and a revision in the lower nibble. The third holds a 3-bit display resolution code. The fourth is a control byte with a resolution-source flag and the active/standby bit. The resolution code, a decoded legality flag, the source flag and the standby state are also brought out as pins for the panel logic.

Top module: `panel_serial_regs`

## Requirements
- R1: While `panel_rst` is high and after it falls, the scratch register reads 0x00, the resolution register reads 0x07, and the control register reads 0x00. In that state `standby` is 1, `res_code` is 7, `res_legal` is 1, `res_sw_ctrl` is 0 and `ser_dout_en` is 0.
- R2: A frame is counted in rising edges of `ser_clk` while `ser_sel` is high. Edges 1 to 6 carry the address, most significant bit first. Edge 7 carries the direction bit (0 write, 1 read). Edge 8 is the turnaround. Edges 9 to 16 carry data, most significant bit first.
- R3: Address 0x00 is a scratch register: any byte written there reads back unchanged.
- R4: Address 0x01 reads {CHIP_ID, CHIP_VER} (default 0xB2), with the identifier in bits 7:4 and the revision in bits 3:0. Writes to it are ignored.
- R5: Address 0x02 keeps only bits 2:0 of a written byte as the resolution code. It reads back as that code with bits 7:3 zero, and the code is driven on `res_code`.
- R6: `res_legal` is 0 when the resolution code is 2 or 3, and 1 for codes 0, 1 and 4 to 7.
- R7: Address 0x03 keeps bit 7, which drives `res_sw_ctrl` (1 = software control), and bit 0 (1 = active, 0 = standby). `standby` is the inverse of bit 0. The other bits read as 0.
- R8: `ser_dout_en` is high only during the data phase of a read frame. It rises after the falling `ser_clk` edge that ends the turnaround clock and is low throughout write frames.
- R9: During a read, each data bit is on `ser_dout` within SYNC_STAGES+2 system clock edges after the falling `ser_clk` edge that precedes its rising edge.
- R10: Dropping `ser_sel` before the 16th rising edge aborts the frame: no register changes, and the next frame is decoded from its first bit.
- R11: Writes to an unmapped address are ignored and reads of one return 0x00.
- R12: Rising `ser_clk` edges after the 16th in the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| panel_rst | input | 1 | Active-high reset, forces register defaults |
| ser_sel | input | 1 | Link enable, high for the duration of a frame |
| ser_clk | input | 1 | Link clock, data sampled on its rising edge |
| ser_din | input | 1 | Serial data from the master |
| ser_dout | output | 1 | Serial read data to the master |
| ser_dout_en | output | 1 | Output enable for `ser_dout` |
| standby | output | 1 | 1 while the control register's active bit is clear |
| res_code | output | 3 | Current resolution code |
| res_legal | output | 1 | 0 for the two reserved resolution codes |
| res_sw_ctrl | output | 1 | Resolution-source flag from the control register |

## Verification
Every link edge reaches the block's logic SYNC_STAGES+1 system clocks after the pin changes. A write commit and its effect on the status pins therefore show up about three system clocks after the 16th rising edge, and a read bit shows up about three clocks after the preceding falling edge. The driver holds each link clock phase for eight system clocks and samples read bits at the end of the low phase, just before it raises the clock, as a real master would. It checks status pins and queued read results only after the enable has been low for sixteen clocks, so every pending effect has settled by the time it samples.

// File: rtl/panel_sreg_pkg.sv
package panel_sreg_pkg;

   localparam int ADR_SCRATCH = 0;
   localparam int ADR_IDENT   = 1;
   localparam int ADR_RESMODE = 2;
   localparam int ADR_CTRL    = 3;

   localparam int RES_W = 3;

   typedef enum logic [1:0] {
      PH_ADDR = 2'd0,
      PH_DIR  = 2'd1,
      PH_TURN = 2'd2,
      PH_DATA = 2'd3
   } frame_phase_e;

   function automatic logic res_code_legal(input logic [RES_W-1:0] code);
      return !(code == 3'd2 || code == 3'd3);
   endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or posedge rst) begin
               if (rst)
                  stage[s] <= '0;
               else if (s == 0)
                  stage[s] <= d;
               else
                  stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
         end
         assign q = stage[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sreg_frame_seq.sv
module sreg_frame_seq
   import panel_sreg_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 8,
   parameter int FRAME_BITS = ADDR_W + 2 + DATA_W,
   parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic              sclk,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              is_read
);

   localparam logic [CNT_W-1:0] CNT_DIR   = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] CNT_TURN  = CNT_W'(ADDR_W + 1);
   localparam logic [CNT_W-1:0] CNT_DATA  = CNT_W'(ADDR_W + 2);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_DONE  = CNT_W'(FRAME_BITS);

   logic                sclk_d;
   logic                rise;
   logic                fall;
   logic [DATA_W-2:0]   wsh;
   logic [DATA_W-1:0]   rsh;
   frame_phase_e        phase;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) sclk_d <= 1'b0;
      else     sclk_d <= sclk;
   end

   assign rise = sclk & ~sclk_d;
   assign fall = ~sclk & sclk_d;

   // phase of the bit carried by the next rising edge
   always_comb begin
      if (bit_cnt < CNT_DIR)       phase = PH_ADDR;
      else if (bit_cnt == CNT_DIR)  phase = PH_DIR;
      else if (bit_cnt == CNT_TURN) phase = PH_TURN;
      else                          phase = PH_DATA;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         bit_cnt <= '0;
         addr    <= '0;
         is_read <= 1'b0;
         wsh     <= '0;
         rsh     <= '0;
         sdo_oe  <= 1'b0;
      end else if (!sel) begin
         bit_cnt <= '0;
         is_read <= 1'b0;
         sdo_oe  <= 1'b0;
      end else begin
         if (rise && bit_cnt != CNT_DONE) begin
            bit_cnt <= bit_cnt + 1'b1;
            case (phase)
               PH_ADDR: addr    <= {addr[ADDR_W-2:0], sdi};
               PH_DIR:  is_read <= sdi;
               PH_DATA: wsh     <= {wsh[DATA_W-3:0], sdi};
               default: ;
            endcase
         end
         if (fall) begin
            if (bit_cnt == CNT_DONE) begin
               sdo_oe <= 1'b0;
            end else if (bit_cnt == CNT_DATA && is_read) begin
               sdo_oe <= 1'b1;
               rsh    <= rd_data;
            end else if (sdo_oe) begin
               rsh    <= {rsh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign wr_stb  = sel && rise && !is_read && (bit_cnt == CNT_LAST);
   assign wr_data = {wsh, sdi};
   assign sdo     = sdo_oe & rsh[DATA_W-1];

endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
   import panel_sreg_pkg::*;
#(
   parameter int           ADDR_W    = 6,
   parameter int           DATA_W    = 8,
   parameter logic [3:0]   CHIP_ID   = 4'hB,
   parameter logic [3:0]   CHIP_VER  = 4'h2,
   parameter logic [2:0]   RES_RESET = 3'd7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [RES_W-1:0]  res_code,
   output logic              res_legal,
   output logic              res_sw,
   output logic              active
);

   localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(ADR_SCRATCH);
   localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(ADR_IDENT);
   localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(ADR_RESMODE);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);

   logic [DATA_W-1:0] scratch;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         scratch  <= '0;
         res_code <= RES_RESET;
         res_sw   <= 1'b0;
         active   <= 1'b0;
      end else if (wr_stb) begin
         case (addr)
            A_SCR:   scratch  <= wr_data;
            A_RES:   res_code <= wr_data[RES_W-1:0];
            A_CTRL: begin
               res_sw <= wr_data[DATA_W-1];
               active <= wr_data[0];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         A_SCR:   rd_data = scratch;
         A_ID:    rd_data = {CHIP_ID, CHIP_VER};
         A_RES:   rd_data = DATA_W'(res_code);
         A_CTRL:  rd_data = {res_sw, {(DATA_W-2){1'b0}}, active};
         default: rd_data = '0;
      endcase
   end

   assign res_legal = res_code_legal(res_code);

endmodule

// File: rtl/panel_serial_regs.sv
module panel_serial_regs
   import panel_sreg_pkg::*;
#(
   parameter int         ADDR_W      = 6,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] CHIP_ID     = 4'hB,
   parameter logic [3:0] CHIP_VER    = 4'h2,
   parameter logic [2:0] RES_RESET   = 3'd7
) (
   input  logic       clk,
   input  logic       panel_rst,
   input  logic       ser_sel,
   input  logic       ser_clk,
   input  logic       ser_din,
   output logic       ser_dout,
   output logic       ser_dout_en,
   output logic       standby,
   output logic [2:0] res_code,
   output logic       res_legal,
   output logic       res_sw_ctrl
);

   localparam int FRAME_BITS = ADDR_W + 2 + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("panel_serial_regs: DATA_W must be 8");
      end
      if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr_w
         $error("panel_serial_regs: ADDR_W must be 2..8");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("panel_serial_regs: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic              sel_s;
   logic              sclk_s;
   logic              sdi_s;
   logic [ADDR_W-1:0] frame_addr;
   logic              wr_stb;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic [CNT_W-1:0]  bit_cnt;
   logic              is_read;
   logic              reg_active;

   sreg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk (clk),
      .rst (panel_rst),
      .d   ({ser_sel, ser_clk, ser_din}),
      .q   ({sel_s, sclk_s, sdi_s})
   );

   sreg_frame_seq #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .FRAME_BITS (FRAME_BITS),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst     (panel_rst),
      .sel     (sel_s),
      .sclk    (sclk_s),
      .sdi     (sdi_s),
      .rd_data (rd_data),
      .addr    (frame_addr),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .sdo     (ser_dout),
      .sdo_oe  (ser_dout_en),
      .bit_cnt (bit_cnt),
      .is_read (is_read)
   );

   sreg_regfile #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CHIP_ID   (CHIP_ID),
      .CHIP_VER  (CHIP_VER),
      .RES_RESET (RES_RESET)
   ) u_regs (
      .clk       (clk),
      .rst       (panel_rst),
      .wr_stb    (wr_stb),
      .addr      (frame_addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .res_code  (res_code),
      .res_legal (res_legal),
      .res_sw    (res_sw_ctrl),
      .active    (reg_active)
   );

   assign standby = ~reg_active;

endmodule

// File: rtl/panel_serial_regs_chk.sv
module panel_serial_regs_chk #(
   parameter int ADDR_W     = 6,
   parameter int FRAME_BITS = 16,
   parameter int CNT_W      = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              sel_s,
   input logic              sdo_oe,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              is_read,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [2:0]        res_code,
   input logic              standby
);

   localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(ADDR_W + 2);
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(FRAME_BITS);
   localparam logic [ADDR_W-1:0] A_RES   = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(3);

   assert_oe_in_read_data_R8: assert property (@(posedge clk) disable iff (rst)
      sdo_oe |-> (is_read && bit_cnt >= CNT_DATA));

   assert_oe_after_turn_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(sdo_oe) |-> (bit_cnt == CNT_DATA));

   assert_commit_at_end_R2: assert property (@(posedge clk) disable iff (rst)
      wr_stb |=> (bit_cnt == CNT_DONE));

   assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
      !sel_s |=> (bit_cnt == '0 && !sdo_oe));

   assert_res_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(wr_stb && wr_addr == A_RES) |=> $stable(res_code));

   assert_standby_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !(wr_stb && wr_addr == A_CTRL) |=> $stable(standby));

endmodule

bind panel_serial_regs panel_serial_regs_chk #(
   .ADDR_W     (ADDR_W),
   .FRAME_BITS (FRAME_BITS),
   .CNT_W      (CNT_W)
) u_chk (
   .clk      (clk),
   .rst      (panel_rst),
   .sel_s    (sel_s),
   .sdo_oe   (ser_dout_en),
   .bit_cnt  (bit_cnt),
   .is_read  (is_read),
   .wr_stb   (wr_stb),
   .wr_addr  (frame_addr),
   .res_code (res_code),
   .standby  (standby)
);

// File: tb/panel_serial_regs_tb.sv
module panel_serial_regs_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HP         = 8;

   logic       clk = 1'b0;
   logic       panel_rst = 1'b1;
   logic       ser_sel = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_din = 1'b0;
   logic       ser_dout;
   logic       ser_dout_en;
   logic       standby;
   logic [2:0] res_code;
   logic       res_legal;
   logic       res_sw_ctrl;

   int n_chk  = 0;
   int n_fail = 0;
   int oe_bad = 0;
   int oe_miss = 0;
   bit oe_allowed = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] rx_byte;
   event       rd_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   panel_serial_regs u_dut (
      .clk         (clk),
      .panel_rst   (panel_rst),
      .ser_sel     (ser_sel),
      .ser_clk     (ser_clk),
      .ser_din     (ser_din),
      .ser_dout    (ser_dout),
      .ser_dout_en (ser_dout_en),
      .standby     (standby),
      .res_code    (res_code),
      .res_legal   (res_legal),
      .res_sw_ctrl (res_sw_ctrl)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive one frame of 'pulses' link clocks
   task automatic frame(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                        input int pulses);
      logic [15:0] v;
      logic [7:0]  got;
      v   = {a, rd, 1'b0, wd};
      got = '0;
      ser_sel = 1'b1;
      wait_clk(HP);
      for (int i = 0; i < pulses; i++) begin
         if (!(rd && i >= 8)) ser_din = (i < 16) ? v[15-i] : 1'b1;
         wait_clk(HP);
         if (rd && i >= 8 && i < 16) begin
            got[15-i] = ser_dout;
            if (!ser_dout_en) oe_miss++;
         end
         ser_clk = 1'b1;
         wait_clk(HP);
         ser_clk = 1'b0;
         if (rd && i == 7) oe_allowed = 1'b1;
      end
      wait_clk(HP);
      ser_sel = 1'b0;
      ser_din = 1'b0;
      wait_clk(2*HP);
      oe_allowed = 1'b0;
      if (rd && pulses >= 16) begin
         rx_byte = got;
         -> rd_done;
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      frame(1'b0, a, d, 16);
   endtask

   task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      frame(1'b1, a, 8'h00, 16);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(rd_done);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected read", int'(rx_byte), 0);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rx_byte === e, t, int'(rx_byte), int'(e));
         end
      end
   end

   // output enable must stay low outside read data windows (R8)
   always @(negedge clk) begin
      if (!panel_rst && ser_dout_en && !oe_allowed) oe_bad++;
   end

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      wait_clk(3);
      // R1 during reset
      chk(standby === 1'b1, "R1 standby in reset", int'(standby), 1);
      chk(res_code === 3'd7, "R1 res_code in reset", int'(res_code), 7);
      chk(ser_dout_en === 1'b0, "R1 dout_en in reset", int'(ser_dout_en), 0);
      wait_clk(2);
      panel_rst = 1'b0;
      wait_clk(4);
      chk(res_legal === 1'b1, "R1 res_legal after reset", int'(res_legal), 1);
      chk(res_sw_ctrl === 1'b0, "R1 res_sw_ctrl after reset", int'(res_sw_ctrl), 0);
      rd(6'h00, 8'h00, "R1 R9 scratch default");
      rd(6'h02, 8'h07, "R1 R9 resolution default");
      rd(6'h03, 8'h00, "R1 R9 control default");

      // R3 scratch
      wr(6'h00, 8'h55);
      rd(6'h00, 8'h55, "R3 scratch 0x55");
      wr(6'h00, 8'hA3);
      rd(6'h00, 8'hA3, "R3 scratch 0xA3");

      // R4 identification
      rd(6'h01, 8'hB2, "R4 id/version");
      wr(6'h01, 8'h00);
      rd(6'h01, 8'hB2, "R4 id after write");

      // R2 address order: 0x20 is unmapped, 0x01 is not
      rd(6'h20, 8'h00, "R2 R11 msb-first address");

      // R5 / R6 resolution
      wr(6'h02, 8'hFC);
      chk(res_code === 3'd4, "R5 res_code 4", int'(res_code), 4);
      chk(res_legal === 1'b1, "R6 code 4 legal", int'(res_legal), 1);
      rd(6'h02, 8'h04, "R5 masked readback");
      wr(6'h02, 8'h02);
      chk(res_legal === 1'b0, "R6 code 2 illegal", int'(res_legal), 0);
      wr(6'h02, 8'h03);
      chk(res_legal === 1'b0, "R6 code 3 illegal", int'(res_legal), 0);
      wr(6'h02, 8'h00);
      chk(res_legal === 1'b1, "R6 code 0 legal", int'(res_legal), 1);
      chk(res_code === 3'd0, "R5 res_code 0", int'(res_code), 0);

      // R7 control
      wr(6'h03, 8'h81);
      chk(standby === 1'b0, "R7 active", int'(standby), 0);
      chk(res_sw_ctrl === 1'b1, "R7 sw control", int'(res_sw_ctrl), 1);
      rd(6'h03, 8'h81, "R7 control readback");
      wr(6'h03, 8'h7E);
      chk(standby === 1'b1, "R7 back to standby", int'(standby), 1);
      chk(res_sw_ctrl === 1'b0, "R7 hw control", int'(res_sw_ctrl), 0);
      rd(6'h03, 8'h00, "R7 unused bits zero");

      // R11 unmapped
      wr(6'h2A, 8'hFF);
      rd(6'h2A, 8'h00, "R11 unmapped read");
      rd(6'h00, 8'hA3, "R11 scratch untouched");

      // R10 abort
      frame(1'b0, 6'h00, 8'h11, 12);
      rd(6'h00, 8'hA3, "R10 aborted write ignored");
      frame(1'b1, 6'h01, 8'h00, 10);
      rd(6'h01, 8'hB2, "R10 next frame decodes");

      // R12 extra clocks
      frame(1'b0, 6'h00, 8'h3C, 19);
      rd(6'h00, 8'h3C, "R12 extra clocks ignored");

      wait_clk(4);
      chk(exp_q.size() == 0, "R2 reads all returned", exp_q.size(), 0);
      chk(oe_bad == 0, "R8 dout_en outside read data", oe_bad, 0);
      chk(oe_miss == 0, "R8 R9 dout_en during read data", oe_miss, 0);
      summary();
   end

endmodule